// File: doc/BRIEF.md
# Interrupt Source Status and Enable Register File

This block holds the per-source state of an interrupt controller. Every source has a raw input, a sense mode, a status bit and an enable bit. The sense mode is set by two bits per source: a type bit (edge or level) and a polarity bit (rising/high or falling/low). The block conditions each raw input by its sense mode, captures the result in the status bit and gates it by the enable bit. The pending vector that results goes to a downstream prioritiser, together with a single global enable that blanks the whole vector when cleared.

Software reaches the state through a 32-bit register bus with single-cycle writes and combinational reads. Single enable or status bits are changed by writing a source number to an index port, so no read-modify-write is needed. Whole words of enables or status bits can also be cleared with a bitmask. The block has no streaming data path. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure: a write takes effect at the clock edge that samples `bus_we_i`, and `bus_rdata_o` follows `bus_addr_i` in the same cycle.

Top module: `intc_status_enable`

## Requirements
- R1: After reset all enable bits, all status bits and the global enable are 0, every polarity bit is 1 and every type bit is 0 (active-high level), so `pend_o` and `glob_en_o` are 0.
- R2: A write of source number k to byte address 0x28 sets enable bit k, and a write of k to 0x2C clears it. A source number that is not below the source count changes no enable bit.
- R3: A write to 0x380+4w clears enable bit 32w+b for every data bit b that is 1. The enable bits read back at 0x300+4w, with source 32w+b in bit b.
- R4: A write of source number k to 0x24 clears the status bit of edge-mode source k. A write to 0x280+4w clears the status bit of edge-mode source 32w+b for every data bit b that is 1.
- R5: The polarity words at 0xD00+4w and the type words at 0xD80+4w are read/write, with source 32w+b in bit b. Bits for sources at or above the source count read 0.
- R6: With type bit 0 (level), the status bit equals the raw input one cycle earlier when polarity is 1, and its inverse when polarity is 0. Status-clear writes have no effect in this mode.
- R7: With type bit 1 (edge), a rising edge (polarity 1) or falling edge (polarity 0) of the raw input sets the status bit one cycle later. The bit then stays 1 after the input returns, until a status-clear write removes it.
- R8: When a status-clear write and a new edge reach the same edge-mode source in the same cycle, the status bit ends up 1.
- R9: Bit 0 of the register at 0x10 is the global enable and reads back. `glob_en_o` follows it. `pend_o` bit k equals status k AND enable k while the global enable is 1, and is all zero while it is 0.
- R10: The index ports, the bitmask clear words and every unmapped address read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | ADDR_W | Byte address; writes and reads hit only when bits 1:0 are zero |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, same cycle |
| src_i | input | NUM_SRC | Raw interrupt inputs, synchronous to `clk` |
| pend_o | output | NUM_SRC | Status AND enable, blanked by the global enable |
| glob_en_o | output | 1 | Global enable for the prioritiser |

## Verification
On every cycle, assertions check three things. In edge mode a status bit stays set unless it is cleared, an edge beats a simultaneous clear, and a clear with no edge empties the bit. In level mode the status bit tracks the conditioned input. An out-of-range index leaves the enables untouched. The pending vector is empty while the global enable is off, and never shows a source whose enable is 0. Only the bench scenarios can show that the register map decodes as specified, that bitmask words reach the right sources in the second word, that the two sense bits combine into the four modes, and that status is retained across an enable toggle.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_GLOB      = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_STAT_IDX  = 12'h024;
  localparam logic [ADDR_W-1:0] OFF_EN_SET    = 12'h028;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR    = 12'h02C;
  localparam logic [ADDR_W-1:0] OFF_STAT_MASK = 12'h280;
  localparam logic [ADDR_W-1:0] OFF_EN_VIEW   = 12'h300;
  localparam logic [ADDR_W-1:0] OFF_EN_MASK   = 12'h380;
  localparam logic [ADDR_W-1:0] OFF_POL       = 12'hD00;
  localparam logic [ADDR_W-1:0] OFF_TYPE      = 12'hD80;

  // word-aligned address of word w inside a region starting at base
  function automatic logic [ADDR_W-3:0] word_of(input logic [ADDR_W-1:0] base, input int w);
    return base[ADDR_W-1:2] + (ADDR_W-2)'(w);
  endfunction
endpackage

// File: rtl/intc_sense_cell.sv
module intc_sense_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic pol_i,
  input  logic edge_i,
  input  logic clr_i,
  output logic stat_o
);
  logic act, act_q, hit, stat_q;

  // polarity folds falling/low onto rising/high
  assign act = pol_i ? raw_i : ~raw_i;
  assign hit = act & ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      act_q <= act;
      if (edge_i) stat_q <= hit | (stat_q & ~clr_i);
      else        stat_q <= act;
    end
  end

  assign stat_o = stat_q;

  a_r6_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_i |=> (stat_o == $past(pol_i ? raw_i : ~raw_i)));
  a_r7_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && stat_o && !clr_i) |=> stat_o);
  a_r4_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && clr_i && !hit) |=> !stat_o);
  a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && clr_i && hit) |=> stat_o);
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] pol_o,
  output logic [NUM_SRC-1:0] type_o,
  output logic [NUM_SRC-1:0] stat_clr_o,
  output logic               glob_o
);
  localparam int WORDS = (NUM_SRC + 31) / 32;
  localparam int PADW  = WORDS * 32;

  logic [NUM_SRC-1:0] en_q, pol_q, type_q;
  logic               glob_q;
  logic               aligned;
  logic [ADDR_W-3:0]  wa;
  logic [PADW-1:0]    en_pad, pol_pad, type_pad;
  logic               idx_ok;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign wa      = addr_i[ADDR_W-1:2];
  assign idx_ok  = (wdata_i < DATA_W'(NUM_SRC));

  function automatic logic hit_at(input logic [ADDR_W-1:0] base, input int w);
    return aligned && (wa == word_of(base, w));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '1;
      type_q <= '0;
      glob_q <= 1'b0;
    end else if (we_i) begin
      if (hit_at(OFF_GLOB, 0)) glob_q <= wdata_i[0];
      for (int i = 0; i < NUM_SRC; i++) begin
        if (hit_at(OFF_EN_SET, 0) && wdata_i == DATA_W'(i))
          en_q[i] <= 1'b1;
        else if ((hit_at(OFF_EN_CLR, 0) && wdata_i == DATA_W'(i)) ||
                 (hit_at(OFF_EN_MASK, i / 32) && wdata_i[i % 32]))
          en_q[i] <= 1'b0;
        if (hit_at(OFF_POL, i / 32))  pol_q[i]  <= wdata_i[i % 32];
        if (hit_at(OFF_TYPE, i / 32)) type_q[i] <= wdata_i[i % 32];
      end
    end
  end

  always_comb begin
    stat_clr_o = '0;
    for (int i = 0; i < NUM_SRC; i++)
      stat_clr_o[i] = we_i &&
        ((hit_at(OFF_STAT_IDX, 0) && wdata_i == DATA_W'(i)) ||
         (hit_at(OFF_STAT_MASK, i / 32) && wdata_i[i % 32]));
  end

  assign en_pad   = PADW'(en_q);
  assign pol_pad  = PADW'(pol_q);
  assign type_pad = PADW'(type_q);

  always_comb begin
    rdata_o = '0;
    if (hit_at(OFF_GLOB, 0)) rdata_o[0] = glob_q;
    for (int w = 0; w < WORDS; w++) begin
      if (hit_at(OFF_EN_VIEW, w)) rdata_o = en_pad[w*32 +: 32];
      if (hit_at(OFF_POL, w))     rdata_o = pol_pad[w*32 +: 32];
      if (hit_at(OFF_TYPE, w))    rdata_o = type_pad[w*32 +: 32];
    end
  end

  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign type_o = type_q;
  assign glob_o = glob_q;

  a_r2_oob_index: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && aligned && (wa == OFF_EN_SET[ADDR_W-1:2] || wa == OFF_EN_CLR[ADDR_W-1:2]) && !idx_ok)
      |=> $stable(en_o));
endmodule

// File: rtl/intc_status_enable.sv
module intc_status_enable
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               glob_en_o
);
  logic [NUM_SRC-1:0] en, pol, typ, clr, stat;
  logic               glob;

  intc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .en_o       (en),
    .pol_o      (pol),
    .type_o     (typ),
    .stat_clr_o (clr),
    .glob_o     (glob)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    intc_sense_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (src_i[g]),
      .pol_i  (pol[g]),
      .edge_i (typ[g]),
      .clr_i  (clr[g]),
      .stat_o (stat[g])
    );
  end

  assign pend_o    = glob ? (stat & en) : '0;
  assign glob_en_o = glob;

  a_r9_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en_o |-> (pend_o == '0));
  a_r9_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o & ~en) == '0));
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (pend_o == '0 && !glob_en_o));
endmodule

// File: tb/test_intc_status_enable.sv
module test_intc_status_enable;
  localparam int N = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] src = '0;
  logic [N-1:0] pend;
  logic         glob;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intc_status_enable #(.NUM_SRC(N)) i_intc_status_enable (
    .clk(clk), .rst_n(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .src_i(src),
    .pend_o(pend), .glob_en_o(glob)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 12'h010, 32'h0000_0000, 4'd1},
    '{1'b0, 12'hD00, 32'hFFFF_FFFF, 4'd5},
    '{1'b0, 12'hD04, 32'h0000_00FF, 4'd5},
    '{1'b0, 12'hD80, 32'h0000_0000, 4'd1},
    '{1'b1, 12'h028, 32'd3,         4'd2},
    '{1'b1, 12'h028, 32'd35,        4'd2},
    '{1'b0, 12'h300, 32'h0000_0008, 4'd2},
    '{1'b0, 12'h304, 32'h0000_0008, 4'd2},
    '{1'b1, 12'h028, 32'd40,        4'd2},
    '{1'b0, 12'h304, 32'h0000_0008, 4'd2},
    '{1'b1, 12'h02C, 32'd3,         4'd2},
    '{1'b0, 12'h300, 32'h0000_0000, 4'd2},
    '{1'b1, 12'h028, 32'd5,         4'd2},
    '{1'b1, 12'h028, 32'd6,         4'd2},
    '{1'b1, 12'h380, 32'h0000_0020, 4'd3},
    '{1'b0, 12'h300, 32'h0000_0040, 4'd3},
    '{1'b0, 12'h028, 32'h0000_0000, 4'd10},
    '{1'b0, 12'h380, 32'h0000_0000, 4'd10},
    '{1'b1, 12'h010, 32'h0000_0001, 4'd9},
    '{1'b0, 12'h010, 32'h0000_0001, 4'd9}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, 64'(rdata), 64'(exp));
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 pend", 64'(pend), 64'(0));
    chk("R1 glob", 64'(glob), 64'(0));
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      if (TBL[k].wr) wr(TBL[k].a, TBL[k].d);
      else rd_chk($sformatf("R%0d vector %0d", TBL[k].req, k), TBL[k].a, TBL[k].d);
    end
    // enables now: sources 6 and 35, global on

    // R6: active-high level on source 6, clear ignored
    @(negedge clk); src[6] = 1'b1;
    tick(); chk("R6 level high", 64'(pend[6]), 64'(1));
    wr(12'h024, 32'd6);
    chk("R6 clear ignored", 64'(pend[6]), 64'(1));
    @(negedge clk); src[6] = 1'b0;
    tick(); chk("R6 level drop", 64'(pend[6]), 64'(0));
    // R6: active-low level
    wr(12'hD00, ~32'h40);
    tick(); chk("R6 active low", 64'(pend[6]), 64'(1));
    @(negedge clk); src[6] = 1'b1;
    tick(); chk("R6 active low off", 64'(pend[6]), 64'(0));

    // R7: falling edge on source 6, sticky
    wr(12'hD80, 32'h40);
    chk("R7 no spurious", 64'(pend[6]), 64'(0));
    @(negedge clk); src[6] = 1'b0;
    @(negedge clk); src[6] = 1'b1;
    chk("R7 falling edge", 64'(pend[6]), 64'(1));
    tick(); chk("R7 falling sticky", 64'(pend[6]), 64'(1));

    // R7: rising edge on source 35, word 1
    wr(12'hD84, 32'h8);
    rd_chk("R5 type word1", 12'hD84, 32'h8);
    @(negedge clk); src[35] = 1'b1;
    @(negedge clk); src[35] = 1'b0;
    chk("R7 rising edge", 64'(pend[35]), 64'(1));
    tick(); chk("R7 rising sticky", 64'(pend[35]), 64'(1));
    // R4: index clear
    wr(12'h024, 32'd35);
    chk("R4 index clear", 64'(pend[35]), 64'(0));

    // R8: clear and new edge in the same cycle
    @(negedge clk); src[35] = 1'b1;
    @(negedge clk); src[35] = 1'b0;
    tick();
    @(negedge clk);
    we = 1'b1; addr = 12'h024; wdata = 32'd35; src[35] = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0; src[35] = 1'b0;
    chk("R8 edge wins", 64'(pend[35]), 64'(1));

    // R3/R9: enable mask clear hides pending, status retained
    wr(12'h384, 32'h8);
    chk("R3 mask enable clear", 64'(pend[35]), 64'(0));
    rd_chk("R3 enable view", 12'h304, 32'h0);
    wr(12'h028, 32'd35);
    chk("R9 status retained", 64'(pend[35]), 64'(1));
    // R4: bitmask status clear in word 1
    wr(12'h284, 32'h8);
    chk("R4 mask clear", 64'(pend[35]), 64'(0));
    chk("R4 mask leaves word0", 64'(pend[6]), 64'(1));

    // R9: global enable off blanks everything
    wr(12'h010, 32'h0);
    chk("R9 global off pend", 64'(pend), 64'(0));
    chk("R9 global off out", 64'(glob), 64'(0));
    rd_chk("R10 unmapped", 12'h014, 32'h0);

    finish_run();
  end
endmodule